// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit orders two IEEE-754 values in half, single or double precision and returns the outcome as a four-bit condition nibble ordered N, Z, C, V. It also returns an invalid-operation bit. Both operand buses are 64 bits wide. A narrower format is read from the low bits of each bus, and the bits above the format width are ignored. A two-bit format code selects the precision. A zero-mode input replaces the second operand with positive zero of the selected format.

The compare is quiet. Any NaN makes the result unordered, but only a signaling NaN raises the invalid bit. Signed zeros compare as equal. Subnormals are compared exactly by sign and magnitude, with no flush to zero.

The result is registered and reported one clock after the input strobe. A two-state controller tracks the output strobe. In `ST_IDLE` the output strobe is low. A cycle with `in_valid` high takes the controller to `ST_RESULT` (transition "capture"). In `ST_RESULT` the output strobe is high. A further `in_valid` keeps it in `ST_RESULT` (transition "stream"). A cycle without `in_valid` returns it to `ST_IDLE` (transition "drain"). Reset forces `ST_IDLE`.

Top module: `fp_cmp_flags`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0, `nzcv` is 4'b0000 and `invalid` is 0.
- R2: `out_valid` is high exactly in the cycle after each cycle in which `in_valid` is high, including back-to-back strobes, and is low otherwise.
- R3: For ordered operands, `nzcv` (bit 3 = N, bit 0 = V) is 4'b1000 when A < B, 4'b0110 when A == B and 4'b0010 when A > B.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), `nzcv` is 4'b0011.
- R5: `invalid` is 1 only when at least one operand taking part in the compare is a signaling NaN, that is, a NaN whose top fraction bit is 0. A quiet NaN (top fraction bit 1) gives 4'b0011 with `invalid` = 0.
- R6: `fmt_sel` 2'b00 selects single precision on bits [31:0]. 2'b01 selects double precision on bits [63:0]. 2'b11 selects half precision on bits [15:0]. 2'b10 is treated as double. Bits above the selected width have no effect.
- R7: With `zero_mode` = 1, `opb` is ignored and B is positive zero. A signaling NaN on `opb` then raises no invalid.
- R8: +0 and -0 compare as equal (4'b0110) in every combination.
- R9: Subnormal values are ordered exactly by sign and magnitude and are never treated as zero.
- R10: -infinity is below every finite value, +infinity is above every finite value, and equal infinities give 4'b0110.
- R11: While `in_valid` is low, `nzcv` and `invalid` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt_sel | input | 2 | Precision code (00 single, 01 double, 11 half, 10 double) |
| zero_mode | input | 1 | Compare A against positive zero |
| opa | input | 64 | First operand, low-aligned |
| opb | input | 64 | Second operand, low-aligned |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| nzcv | output | 4 | Condition nibble {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation exception (signaling NaN seen) |

## Verification
Two paths are hard to reach at random: a signaling NaN on `opb` that zero mode must hide, and sign-and-magnitude ordering among negative subnormals right next to the zeros. A random draw almost never lands on either. The bench therefore sweeps every ordered pair from a hand-picked half-precision value set that contains both zeros, the smallest and largest subnormals of each sign, the infinities, and quiet and signaling NaNs of each sign. It repeats the same kind of sweep in single and double precision. It then runs a zero-mode pass with a signaling NaN parked on `opb`, and a pass with garbage in the unused upper bits.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int OPW   = 64;
    localparam int MAGW  = OPW - 1;
    localparam int NFMT  = 3;
    localparam int FLGW  = 4;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_RSVD   = 2'b10,
        FMT_HALF   = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ORD_LT,
        ORD_EQ,
        ORD_GT,
        ORD_UN
    } ord_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } st_e;

    typedef struct packed {
        logic            sign;
        logic [MAGW-1:0] mag;
        logic            is_zero;
        logic            is_inf;
        logic            is_nan;
        logic            is_snan;
    } opnd_t;

    localparam logic [FLGW-1:0] FLG_LT = 4'b1000;
    localparam logic [FLGW-1:0] FLG_EQ = 4'b0110;
    localparam logic [FLGW-1:0] FLG_GT = 4'b0010;
    localparam logic [FLGW-1:0] FLG_UN = 4'b0011;

    // index 0 single, 1 double, 2 half
    function automatic int exp_width(int idx);
        case (idx)
            0:       return 8;
            1:       return 11;
            default: return 5;
        endcase
    endfunction

    function automatic int frac_width(int idx);
        case (idx)
            0:       return 23;
            1:       return 52;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/fpc_field_class.sv
module fpc_field_class
    import fpc_pkg::*;
#(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input  logic [OPW-1:0] word,
    output opnd_t          cls
);
    localparam int BODYW = EW + FW;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_max;
    logic          frac_nz;

    always_comb begin
        exp_f   = word[BODYW-1:FW];
        frac_f  = word[FW-1:0];
        exp_max = &exp_f;
        frac_nz = |frac_f;

        cls.sign    = word[BODYW];
        cls.mag     = MAGW'(word[BODYW-1:0]);
        cls.is_zero = ~(|exp_f) & ~frac_nz;
        cls.is_inf  = exp_max & ~frac_nz;
        cls.is_nan  = exp_max & frac_nz;
        cls.is_snan = exp_max & frac_nz & ~frac_f[FW-1];
    end

endmodule

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpc_pkg::*;
(
    input  logic [OPW-1:0] word,
    input  fmt_e           fmt,
    input  logic           force_zero,
    output opnd_t          cls
);
    opnd_t per_fmt [NFMT];

    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        fpc_field_class #(
            .EW (exp_width(g)),
            .FW (frac_width(g))
        ) u_cls (
            .word (word),
            .cls  (per_fmt[g])
        );
    end

    always_comb begin
        if (force_zero) begin
            cls         = '0;
            cls.is_zero = 1'b1;
        end else begin
            unique case (fmt)
                FMT_SINGLE: cls = per_fmt[0];
                FMT_HALF:   cls = per_fmt[2];
                default:    cls = per_fmt[1];
            endcase
        end
    end

endmodule

// File: rtl/fpc_order.sv
module fpc_order
    import fpc_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output ord_e  ord,
    output logic  sig_nan
);
    logic mag_eq;
    logic mag_lt;

    always_comb begin
        mag_eq  = (a.mag == b.mag);
        mag_lt  = (a.mag <  b.mag);
        sig_nan = a.is_snan | b.is_snan;

        if (a.is_nan || b.is_nan) begin
            ord = ORD_UN;
        end else if (a.is_zero && b.is_zero) begin
            ord = ORD_EQ;
        end else if (a.sign != b.sign) begin
            ord = a.sign ? ORD_LT : ORD_GT;
        end else if (mag_eq) begin
            ord = ORD_EQ;
        end else if (mag_lt ^ a.sign) begin
            ord = ORD_LT;
        end else begin
            ord = ORD_GT;
        end
    end

endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
    import fpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       fmt_sel,
    input  logic             zero_mode,
    input  logic [OPW-1:0]   opa,
    input  logic [OPW-1:0]   opb,
    output logic             out_valid,
    output logic [FLGW-1:0]  nzcv,
    output logic             invalid
);
    fmt_e  fmt;
    opnd_t cls_a;
    opnd_t cls_b;
    ord_e  ord;
    logic  sig_nan;
    logic [FLGW-1:0] flg_d;

    st_e state_q;
    st_e state_d;

    assign fmt = fmt_e'(fmt_sel);

    fpc_unpack u_unp_a (
        .word       (opa),
        .fmt        (fmt),
        .force_zero (1'b0),
        .cls        (cls_a)
    );

    fpc_unpack u_unp_b (
        .word       (opb),
        .fmt        (fmt),
        .force_zero (zero_mode),
        .cls        (cls_b)
    );

    fpc_order u_ord (
        .a       (cls_a),
        .b       (cls_b),
        .ord     (ord),
        .sig_nan (sig_nan)
    );

    always_comb begin
        unique case (ord)
            ORD_LT:  flg_d = FLG_LT;
            ORD_EQ:  flg_d = FLG_EQ;
            ORD_GT:  flg_d = FLG_GT;
            default: flg_d = FLG_UN;
        endcase
    end

    // next-state: capture / stream / drain
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nzcv    <= '0;
            invalid <= 1'b0;
        end else if (in_valid) begin
            nzcv    <= flg_d;
            invalid <= sig_nan;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESULT: out_valid = 1'b1;
            default:   out_valid = 1'b0;
        endcase
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nzcv == FLG_LT || nzcv == FLG_EQ ||
                       nzcv == FLG_GT || nzcv == FLG_UN)); // R3
    AST_INVALID_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> (nzcv == FLG_UN)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(nzcv) && $stable(invalid))); // R11
    AST_ZERO_SNAN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode && !cls_a.is_snan) |=> !invalid); // R7

endmodule

// File: tb/sim_fp_cmp_flags.sv
`timescale 1ns/1ps
module sim_fp_cmp_flags;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  fmt_sel;
    logic        zero_mode;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_valid;
    logic [3:0]  nzcv;
    logic        invalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    fp_cmp_flags u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .fmt_sel (fmt_sel), .zero_mode (zero_mode),
        .opa (opa), .opb (opb),
        .out_valid (out_valid), .nzcv (nzcv), .invalid (invalid)
    );

    logic [15:0] hv [24] = '{
        16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h0002, 16'h0200,
        16'h03FF, 16'h83FF, 16'h0400, 16'h8400, 16'h3BFF, 16'h3C00,
        16'hBC00, 16'h3C01, 16'h4000, 16'hC000, 16'h7BFF, 16'hFBFF,
        16'h7C00, 16'hFC00, 16'h7E00, 16'hFE00, 16'h7C01, 16'hFD00};

    logic [31:0] sv [16] = '{
        32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
        32'h00400000, 32'h00800000, 32'h3F800000, 32'hBF800000,
        32'h3F800001, 32'h40490FDB, 32'h7F7FFFFF, 32'h7F800000,
        32'hFF800000, 32'h7FC00000, 32'h7F800001, 32'hFFA00000};

    logic [63:0] dv [12] = '{
        64'h0000000000000000, 64'h8000000000000000, 64'h0000000000000001,
        64'h800FFFFFFFFFFFFF, 64'h3FF0000000000000, 64'hBFF0000000000000,
        64'h3FF0000000000001, 64'h400921FB54442D18, 64'h7FF0000000000000,
        64'hFFF0000000000000, 64'h7FF8000000000000, 64'h7FF0000000000001};

    function automatic int ew_of(logic [1:0] f);
        return (f == 2'b00) ? 8 : (f == 2'b11) ? 5 : 11;
    endfunction

    function automatic int fw_of(logic [1:0] f);
        return (f == 2'b00) ? 23 : (f == 2'b11) ? 10 : 52;
    endfunction

    // field view of one operand: {nan, snan, zero, subnormal, inf}
    function automatic logic [4:0] kind(logic [63:0] x, int ew, int fw);
        logic [63:0] body, e, fr, emax;
        body = x & ((64'd1 << (ew + fw)) - 64'd1);
        e    = body >> fw;
        fr   = body & ((64'd1 << fw) - 64'd1);
        emax = (64'd1 << ew) - 64'd1;
        return {(e == emax) && (fr != 0),
                (e == emax) && (fr != 0) && (((fr >> (fw - 1)) & 64'd1) == 0),
                body == 0, (e == 0) && (fr != 0), (e == emax) && (fr == 0)};
    endfunction

    function automatic longint sval(logic [63:0] x, int ew, int fw);
        longint m;
        m = longint'(x & ((64'd1 << (ew + fw)) - 64'd1));
        return x[ew + fw] ? -m : m;
    endfunction

    // expected {nzcv, invalid}
    function automatic logic [4:0] ref_cmp(logic [1:0] f, bit zm,
                                           logic [63:0] a, logic [63:0] b);
        int ew = ew_of(f);
        int fw = fw_of(f);
        logic [63:0] bb = zm ? 64'd0 : b;
        logic [4:0] ka = kind(a, ew, fw);
        logic [4:0] kb = kind(bb, ew, fw);
        longint va = sval(a, ew, fw);
        longint vb = sval(bb, ew, fw);
        if (ka[4] || kb[4]) return {4'b0011, ka[3] | kb[3]};
        if (va < vb)        return {4'b1000, 1'b0};
        if (va == vb)       return {4'b0110, 1'b0};
        return {4'b0010, 1'b0};
    endfunction

    function automatic string tag_of(logic [1:0] f, bit zm,
                                     logic [63:0] a, logic [63:0] b);
        int ew = ew_of(f);
        int fw = fw_of(f);
        logic [4:0] ka = kind(a, ew, fw);
        logic [4:0] kb = kind(zm ? 64'd0 : b, ew, fw);
        if (ka[3] || kb[3]) return "R5";
        if (ka[4] || kb[4]) return "R4";
        if (ka[2] && kb[2]) return "R8";
        if (ka[1] || kb[1]) return "R9";
        if (ka[0] || kb[0]) return "R10";
        return "R3";
    endfunction

    task automatic apply(input logic [1:0] f, input bit zm,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] a_ref, input logic [63:0] b_ref,
                         input string pre);
        logic [4:0] ex;
        string      tg;
        ex = ref_cmp(f, zm, a_ref, b_ref);
        tg = {pre, tag_of(f, zm, a_ref, b_ref)};
        fmt_sel = f; zero_mode = zm; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2 out_valid actual=%b expected=1", out_valid);
        end
        n_tests++;
        if ({nzcv, invalid} !== ex) begin
            n_fail++;
            $display("FAIL %s fmt=%b zm=%0d a=%h b=%h actual=%b_%b expected=%b_%b",
                     tg, f, zm, a, b, nzcv, invalid, ex[4:1], ex[0]);
        end
    endtask

    task automatic expect_eq(input string tg, input logic [4:0] act,
                             input logic [4:0] exv);
        n_tests++;
        if (act !== exv) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tg, act, exv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] junk;
        logic [3:0]  held;
        logic        held_inv;
        junk = 64'hA5C3_96E1_5A3C_0000;
        rst_n = 1'b0; in_valid = 1'b0; fmt_sel = 2'b00; zero_mode = 1'b0;
        opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        expect_eq("R1 in reset", {out_valid, nzcv}, 5'b0);
        expect_eq("R1 invalid in reset", {4'b0, invalid}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R1 after release", {out_valid, nzcv}, 5'b0);

        // half precision, all pairs, back-to-back strobes
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
                apply(2'b11, 1'b0, {48'd0, hv[i]}, {48'd0, hv[j]},
                      {48'd0, hv[i]}, {48'd0, hv[j]}, "");
        // upper bits must not matter
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
                apply(2'b11, 1'b0, junk | {48'd0, hv[i]},
                      ~junk & {48'hFFFF_FFFF_FFFF, 16'd0} | {48'd0, hv[j]},
                      {48'd0, hv[i]}, {48'd0, hv[j]}, "R6/");
        // zero mode with a signaling NaN on the ignored operand
        for (int i = 0; i < 24; i++)
            apply(2'b11, 1'b1, {48'd0, hv[i]}, {48'd0, 16'h7D00},
                  {48'd0, hv[i]}, 64'd0, "R7/");

        // single precision
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                apply(2'b00, 1'b0, {junk[63:32], sv[i]}, {32'd0, sv[j]},
                      {32'd0, sv[i]}, {32'd0, sv[j]}, "R6/");
        for (int i = 0; i < 16; i++)
            apply(2'b00, 1'b1, {32'd0, sv[i]}, 64'h0000_0000_7F80_0001,
                  {32'd0, sv[i]}, 64'd0, "R7/");

        // double precision and the reserved code
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++) begin
                apply(2'b01, 1'b0, dv[i], dv[j], dv[i], dv[j], "");
                apply(2'b10, 1'b0, dv[i], dv[j], dv[i], dv[j], "R6/");
            end
        for (int i = 0; i < 12; i++)
            apply(2'b01, 1'b1, dv[i], 64'h7FF0_0000_0000_0001, dv[i], 64'd0, "R7/");

        // idle cycles: strobe drops, flags hold
        apply(2'b11, 1'b0, 64'h7C01, 64'h0000, 64'h7C01, 64'h0000, "");
        held = nzcv; held_inv = invalid;
        in_valid = 1'b0; opa = 64'h3C00; opb = 64'h4000; fmt_sel = 2'b11;
        zero_mode = 1'b0;
        @(negedge clk);
        expect_eq("R2 strobe drops", {4'b0, out_valid}, 5'b0);
        expect_eq("R11 hold", {nzcv, invalid}, {held, held_inv});
        @(negedge clk);
        expect_eq("R11 hold second cycle", {nzcv, invalid}, {held, held_inv});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule